// File: doc/BRIEF.md
# Multi-path context fork tracker

This block keeps the bookkeeping for hardware thread contexts on one core that run both sides of a hard-to-predict branch at once. When a speculative thread reports a low-confidence branch, the tracker claims an idle context for the other target and marks both contexts as being in multi-path mode. Each context holds a mode bit, a count of the forked branches it still sits under, and one direction bit per nesting level that says which target it followed.

When a forked branch resolves, the resolution input names the nesting level and the actual outcome. Every context under that level whose direction bit disagrees is discarded and goes back to the idle pool. Survivors lose that level: their count drops by one and the direction bits above the level move down by one place. A context whose count reaches zero leaves multi-path mode. While any context is in multi-path mode, the block withholds grants for commit, kill, restart and spawn requests, so a violation seen on a path that later turns out wrong never squashes anything.

Context 0 holds the thread after reset. Forks are only taken from the deepest live path, so each nesting level belongs to exactly one forked branch at any time.

Top module: `mpf_tracker`

## Requirements
- R1: After reset only context 0 is active; every context has mode 0, count 0 and direction bits 0, and no fork acknowledge or discard is signalled.
- R2: A taken fork from source context s at count d gives s count d+1 with its direction bits unchanged. It activates the lowest-numbered idle context with count d+1, mode 1 and direction bits equal to those of s with bit d set. `fork_ack` pulses and `fork_child` names that context in the cycle after the request.
- R3: A fork request while no context is idle is ignored: no acknowledge, and the set of active contexts does not change.
- R4: A fork request is ignored when the source is inactive, when its count already equals DEPTH (3 by default), or when its count is below the largest count among active contexts.
- R5: A resolution at level L with outcome o clears, in the next cycle, every active context whose count exceeds L and whose direction bit L differs from o. Those contexts show in `discard_mask` for exactly that one cycle.
- R6: A surviving context under level L takes count minus one. Its direction bits below L keep their places, the bits above L each move down one place, and the top bit becomes 0. Its mode bit is 1 exactly while its count is nonzero.
- R7: `commit_ok`, `kill_ok` and `spawn_ok` follow their requests in the same cycle when no context is in multi-path mode, and are 0 whenever any context is.
- R8: `restart_ok` is 1 only when `restart_req` is set, no context is in multi-path mode, and the context named by `restart_ctx` is active.
- R9: A fork request in the same cycle as a resolution is ignored.
- R10: A resolution at level L leaves every context with a count of L or less unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fork_req | input | 1 | Low-confidence branch seen by a context |
| fork_src | input | IW | Context that saw the branch |
| res_valid | input | 1 | A forked branch has resolved |
| res_level | input | LW | Nesting level of the resolved branch |
| res_dir | input | 1 | Actual outcome of the resolved branch |
| commit_req | input | 1 | Thread asks to commit |
| kill_req | input | 1 | Thread asks to be killed |
| spawn_req | input | 1 | Thread asks to spawn a successor |
| restart_req | input | 1 | A context asks to restart after a violation |
| restart_ctx | input | IW | Context that asks to restart |
| commit_ok | output | 1 | Commit granted |
| kill_ok | output | 1 | Kill granted |
| spawn_ok | output | 1 | Spawn granted |
| restart_ok | output | 1 | Restart granted |
| fork_ack | output | 1 | One-cycle pulse: a fork was taken |
| fork_child | output | IW | Context claimed by the last taken fork |
| ctx_active | output | NCTX | Context is in use |
| ctx_mp | output | NCTX | Context is in multi-path mode |
| ctx_paths | output | NCTX*PW | Per-context outstanding forked-branch count |
| ctx_dir | output | NCTX*DEPTH | Per-context direction bits, one per level |
| discard_mask | output | NCTX | One-cycle pulse: contexts dropped by the last resolution |

## Verification
The fork logic is driven with a single fork, a nested fork, a fork from a shallower sibling, a fork at full depth, and a fork that collides with a resolution. These separate the acceptance rules from one another and show the lowest-free choice. A second, smaller instance gets the same stimulus so that running out of idle contexts can be told apart from the depth limit. Resolutions are applied at the deepest level, at a middle level with an untouched shallower sibling, and at level 0 with deeper survivors. This shows the discard choice, the untouched contexts, and the shifting down of the bits above the level, which a plain clear would not produce. The grant outputs are sampled both in and out of multi-path mode, with restarts named for an active and an idle context.

// File: rtl/mpf_pkg.sv
// Shared definitions for the multi-path fork tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package mpf_pkg;
    // Default geometry: contexts per core and direction bits per context
    localparam int unsigned MPF_CTX_DEFAULT   = 6;
    localparam int unsigned MPF_DEPTH_DEFAULT = 3;
    localparam int unsigned MPF_PW_DEFAULT    = 3;

    // What a context slot does on a given clock edge
    typedef enum logic [2:0] {
        SLOT_HOLD,
        SLOT_DROP,
        SLOT_SHIFT,
        SLOT_CHILD,
        SLOT_PARENT
    } slot_act_e;
endpackage

// File: rtl/mpf_alloc.sv
// Finds the lowest-numbered idle context.
// Assumes: NCTX >= 2; IW wide enough to hold NCTX-1.
module mpf_alloc #(
    parameter int unsigned NCTX = 6,
    parameter int unsigned IW   = 3
) (
    input  logic [NCTX-1:0] in_use,
    output logic            found,
    output logic [IW-1:0]   idx
);
    // Scan from the top so that the lowest idle index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCTX - 1; i >= 0; i--) begin
            if (!in_use[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mpf_slot.sv
// State of one hardware context: active, mode bit, branch count, direction bits.
// Assumes: the top never raises take_child or bump_parent together with res_valid,
// and only one forked branch is live per level.
module mpf_slot
    import mpf_pkg::*;
#(
    parameter int unsigned IDX   = 0,
    parameter int unsigned DEPTH = 3,
    parameter int unsigned PW    = 3,
    parameter int unsigned LW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_child,
    input  logic             bump_parent,
    input  logic [DEPTH-1:0] child_dir,
    input  logic [PW-1:0]    child_paths,
    input  logic             res_valid,
    input  logic [LW-1:0]    res_level,
    input  logic             res_dir,
    output logic             active,
    output logic             mp,
    output logic [PW-1:0]    paths,
    output logic [DEPTH-1:0] dir,
    output logic             dropping
);
    logic             under;
    logic [DEPTH-1:0] dir_shift;
    slot_act_e        act;

    // Is this context beneath the resolving level, and does it lose?
    always_comb begin
        under    = active && res_valid && (int'(paths) > int'(res_level));
        dropping = under && (dir[res_level] != res_dir);
    end

    // Remove bit res_level: lower bits stay, upper bits move down one place
    always_comb begin
        for (int k = 0; k < DEPTH - 1; k++) begin
            dir_shift[k] = (k < int'(res_level)) ? dir[k] : dir[k+1];
        end
        dir_shift[DEPTH-1] = (DEPTH - 1 < int'(res_level)) ? dir[DEPTH-1] : 1'b0;
    end

    // Choose this cycle's action; resolution outranks fork
    always_comb begin
        if (dropping)         act = SLOT_DROP;
        else if (under)       act = SLOT_SHIFT;
        else if (take_child)  act = SLOT_CHILD;
        else if (bump_parent) act = SLOT_PARENT;
        else                  act = SLOT_HOLD;
    end

    // Context state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= (IDX == 0);
            mp     <= 1'b0;
            paths  <= '0;
            dir    <= '0;
        end else begin
            case (act)
                SLOT_DROP: begin
                    active <= 1'b0;
                    mp     <= 1'b0;
                    paths  <= '0;
                    dir    <= '0;
                end
                SLOT_SHIFT: begin
                    paths <= paths - PW'(1);
                    dir   <= dir_shift;
                    mp    <= (paths != PW'(1));
                end
                SLOT_CHILD: begin
                    active <= 1'b1;
                    mp     <= 1'b1;
                    paths  <= child_paths;
                    dir    <= child_dir;
                end
                SLOT_PARENT: begin
                    paths <= paths + PW'(1);
                    mp    <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mpf_tracker.sv
// Multi-path fork tracker: forks a context onto the other branch target,
// prunes wrong paths on resolution, and withholds thread-level grants meanwhile.
// Assumes: forks come only from the deepest path; DEPTH < 2**PW.
module mpf_tracker
    import mpf_pkg::*;
#(
    parameter int unsigned NCTX  = MPF_CTX_DEFAULT,
    parameter int unsigned DEPTH = MPF_DEPTH_DEFAULT,
    parameter int unsigned PW    = MPF_PW_DEFAULT,
    localparam int unsigned IW   = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int unsigned LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fork_req,
    input  logic [IW-1:0]         fork_src,
    input  logic                  res_valid,
    input  logic [LW-1:0]         res_level,
    input  logic                  res_dir,
    input  logic                  commit_req,
    input  logic                  kill_req,
    input  logic                  spawn_req,
    input  logic                  restart_req,
    input  logic [IW-1:0]         restart_ctx,
    output logic                  commit_ok,
    output logic                  kill_ok,
    output logic                  spawn_ok,
    output logic                  restart_ok,
    output logic                  fork_ack,
    output logic [IW-1:0]         fork_child,
    output logic [NCTX-1:0]       ctx_active,
    output logic [NCTX-1:0]       ctx_mp,
    output logic [NCTX*PW-1:0]    ctx_paths,
    output logic [NCTX*DEPTH-1:0] ctx_dir,
    output logic [NCTX-1:0]       discard_mask
);
    logic [PW-1:0]    paths_arr [NCTX];
    logic [DEPTH-1:0] dir_arr   [NCTX];
    logic [NCTX-1:0]  drop_vec;
    logic             free_found;
    logic [IW-1:0]    free_idx;
    logic             src_active;
    logic [PW-1:0]    src_paths;
    logic [DEPTH-1:0] src_dir;
    logic [PW-1:0]    max_paths;
    logic             fork_take;
    logic             busy;
    logic             rs_active;

    mpf_alloc #(.NCTX(NCTX), .IW(IW)) u_alloc (
        .in_use (ctx_active),
        .found  (free_found),
        .idx    (free_idx)
    );

    // Select the fork source's state and the deepest live count
    always_comb begin
        src_active = 1'b0;
        src_paths  = '0;
        src_dir    = '0;
        max_paths  = '0;
        for (int i = 0; i < NCTX; i++) begin
            if (fork_src == IW'(i)) begin
                src_active = ctx_active[i];
                src_paths  = paths_arr[i];
                src_dir    = dir_arr[i];
            end
            if (ctx_active[i] && (paths_arr[i] > max_paths)) max_paths = paths_arr[i];
        end
    end

    // Fork acceptance: idle context, depth room, deepest path, no resolution now
    always_comb begin
        fork_take = fork_req && !res_valid && src_active && free_found &&
                    (int'(src_paths) < DEPTH) && (src_paths == max_paths);
    end

    for (genvar g = 0; g < NCTX; g++) begin : g_slot
        mpf_slot #(.IDX(g), .DEPTH(DEPTH), .PW(PW), .LW(LW)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .take_child  (fork_take && (free_idx == IW'(g))),
            .bump_parent (fork_take && (fork_src == IW'(g))),
            .child_dir   (src_dir | (DEPTH'(1) << src_paths)),
            .child_paths (src_paths + PW'(1)),
            .res_valid   (res_valid),
            .res_level   (res_level),
            .res_dir     (res_dir),
            .active      (ctx_active[g]),
            .mp          (ctx_mp[g]),
            .paths       (paths_arr[g]),
            .dir         (dir_arr[g]),
            .dropping    (drop_vec[g])
        );
        assign ctx_paths[g*PW +: PW]       = paths_arr[g];
        assign ctx_dir[g*DEPTH +: DEPTH]   = dir_arr[g];
    end

    // Fork acknowledge and discard pulses, one cycle after the cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fork_ack     <= 1'b0;
            fork_child   <= '0;
            discard_mask <= '0;
        end else begin
            fork_ack     <= fork_take;
            discard_mask <= drop_vec;
            if (fork_take) fork_child <= free_idx;
        end
    end

    // Look up whether the restarting context is live
    always_comb begin
        rs_active = 1'b0;
        for (int i = 0; i < NCTX; i++) begin
            if (restart_ctx == IW'(i)) rs_active = ctx_active[i];
        end
    end

    // Thread-level grants are withheld while any path is speculative
    always_comb begin
        busy       = |ctx_mp;
        commit_ok  = commit_req && !busy;
        kill_ok    = kill_req && !busy;
        spawn_ok   = spawn_req && !busy;
        restart_ok = restart_req && !busy && rs_active;
    end
endmodule

// File: rtl/mpf_tracker_chk.sv
// Assertion checker for mpf_tracker, attached with bind below.
// Assumes: the same parameters as the bound instance.
module mpf_tracker_chk #(
    parameter int unsigned NCTX  = 6,
    parameter int unsigned DEPTH = 3,
    parameter int unsigned PW    = 3,
    parameter int unsigned IW    = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fork_req,
    input logic                  res_valid,
    input logic                  restart_req,
    input logic                  commit_ok,
    input logic                  kill_ok,
    input logic                  spawn_ok,
    input logic                  restart_ok,
    input logic                  fork_ack,
    input logic [IW-1:0]         fork_child,
    input logic [NCTX-1:0]       ctx_active,
    input logic [NCTX-1:0]       ctx_mp,
    input logic [NCTX*PW-1:0]    ctx_paths,
    input logic [NCTX-1:0]       discard_mask
);
    logic child_live;

    // Whether the acknowledged child is shown active
    always_comb begin
        child_live = 1'b0;
        for (int i = 0; i < NCTX; i++) begin
            if (fork_child == IW'(i)) child_live = ctx_active[i];
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (ctx_active == NCTX'(1)) && (ctx_mp == '0) && !fork_ack);

    assert_child_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fork_ack |-> child_live);

    assert_no_fork_on_resolve_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fork_ack |-> ($past(fork_req) && !$past(res_valid)));

    assert_discard_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_mask & ctx_active) == '0);

    assert_discard_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|discard_mask) |-> $past(res_valid));

    assert_grants_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctx_mp) |-> (!commit_ok && !kill_ok && !spawn_ok));

    assert_restart_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_ok |-> (restart_req && !(|ctx_mp)));

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        assert_mode_tracks_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ctx_mp[g] == (ctx_paths[g*PW +: PW] != '0));
        assert_depth_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(ctx_paths[g*PW +: PW]) <= DEPTH);
    end
endmodule

bind mpf_tracker mpf_tracker_chk #(
    .NCTX(NCTX), .DEPTH(DEPTH), .PW(PW), .IW(IW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fork_req     (fork_req),
    .res_valid    (res_valid),
    .restart_req  (restart_req),
    .commit_ok    (commit_ok),
    .kill_ok      (kill_ok),
    .spawn_ok     (spawn_ok),
    .restart_ok   (restart_ok),
    .fork_ack     (fork_ack),
    .fork_child   (fork_child),
    .ctx_active   (ctx_active),
    .ctx_mp       (ctx_mp),
    .ctx_paths    (ctx_paths),
    .discard_mask (discard_mask)
);

// File: tb/mpf_tracker_bench.sv
// Directed bench for mpf_tracker: one task per scenario, each checking itself.
// A second, three-context instance receives the same stimulus for the exhaustion case.
module mpf_tracker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fork_req = 1'b0;
    logic [2:0] fork_src = '0;
    logic       res_valid = 1'b0;
    logic [1:0] res_level = '0;
    logic       res_dir = 1'b0;
    logic       commit_req = 1'b0, kill_req = 1'b0, spawn_req = 1'b0, restart_req = 1'b0;
    logic [2:0] restart_ctx = '0;

    logic       commit_ok, kill_ok, spawn_ok, restart_ok, fork_ack;
    logic [2:0] fork_child;
    logic [5:0] ctx_active, ctx_mp, discard_mask;
    logic [17:0] ctx_paths, ctx_dir;

    logic       n_commit_ok, n_kill_ok, n_spawn_ok, n_restart_ok, n_fork_ack;
    logic [1:0] n_fork_child;
    logic [2:0] n_active, n_mp, n_discard;
    logic [8:0] n_paths, n_dir;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mpf_tracker u_mpf_tracker (
        .clk(clk), .rst_n(rst_n), .fork_req(fork_req), .fork_src(fork_src),
        .res_valid(res_valid), .res_level(res_level), .res_dir(res_dir),
        .commit_req(commit_req), .kill_req(kill_req), .spawn_req(spawn_req),
        .restart_req(restart_req), .restart_ctx(restart_ctx),
        .commit_ok(commit_ok), .kill_ok(kill_ok), .spawn_ok(spawn_ok),
        .restart_ok(restart_ok), .fork_ack(fork_ack), .fork_child(fork_child),
        .ctx_active(ctx_active), .ctx_mp(ctx_mp), .ctx_paths(ctx_paths),
        .ctx_dir(ctx_dir), .discard_mask(discard_mask)
    );

    mpf_tracker #(.NCTX(3), .DEPTH(3), .PW(3)) u_mpf_tracker_narrow (
        .clk(clk), .rst_n(rst_n), .fork_req(fork_req), .fork_src(fork_src[1:0]),
        .res_valid(res_valid), .res_level(res_level), .res_dir(res_dir),
        .commit_req(commit_req), .kill_req(kill_req), .spawn_req(spawn_req),
        .restart_req(restart_req), .restart_ctx(restart_ctx[1:0]),
        .commit_ok(n_commit_ok), .kill_ok(n_kill_ok), .spawn_ok(n_spawn_ok),
        .restart_ok(n_restart_ok), .fork_ack(n_fork_ack), .fork_child(n_fork_child),
        .ctx_active(n_active), .ctx_mp(n_mp), .ctx_paths(n_paths),
        .ctx_dir(n_dir), .discard_mask(n_discard)
    );

    function automatic int pth(input int i);
        return int'(ctx_paths[i*3 +: 3]);
    endfunction

    function automatic int drb(input int i);
        return int'(ctx_dir[i*3 +: 3]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock of stimulus: drive after a falling edge, release after the next
    task automatic cycle(input bit f, input int src, input bit r, input int lvl, input bit d);
        fork_req  = f;
        fork_src  = 3'(src);
        res_valid = r;
        res_level = 2'(lvl);
        res_dir   = d;
        @(negedge clk);
        fork_req  = 1'b0;
        res_valid = 1'b0;
    endtask

    task automatic grants(input int rctx, output int c, output int k, output int s, output int r);
        commit_req = 1'b1; kill_req = 1'b1; spawn_req = 1'b1; restart_req = 1'b1;
        restart_ctx = 3'(rctx);
        #1;
        c = int'(commit_ok); k = int'(kill_ok); s = int'(spawn_ok); r = int'(restart_ok);
        commit_req = 1'b0; kill_req = 1'b0; spawn_req = 1'b0; restart_req = 1'b0;
    endtask

    task automatic t_reset;
        int c, k, s, r;
        chk("R1 active", int'(ctx_active), 1);
        chk("R1 mode", int'(ctx_mp), 0);
        chk("R1 paths", int'(ctx_paths), 0);
        chk("R1 dir", int'(ctx_dir), 0);
        chk("R1 ack", int'(fork_ack), 0);
        chk("R1 discard", int'(discard_mask), 0);
        grants(0, c, k, s, r);
        chk("R7 commit idle", c, 1);
        chk("R7 kill idle", k, 1);
        chk("R7 spawn idle", s, 1);
        chk("R8 restart ctx0 idle", r, 1);
    endtask

    task automatic t_first_fork;
        int c, k, s, r;
        cycle(1, 0, 0, 0, 0);
        chk("R2 ack", int'(fork_ack), 1);
        chk("R2 child", int'(fork_child), 1);
        chk("R2 active", int'(ctx_active), 6'b000011);
        chk("R2 parent paths", pth(0), 1);
        chk("R2 parent dir", drb(0), 0);
        chk("R2 child paths", pth(1), 1);
        chk("R2 child dir", drb(1), 1);
        chk("R2 mode", int'(ctx_mp), 6'b000011);
        grants(0, c, k, s, r);
        chk("R7 commit held", c, 0);
        chk("R7 kill held", k, 0);
        chk("R7 spawn held", s, 0);
        chk("R8 restart held", r, 0);
    endtask

    task automatic t_nested_fork;
        cycle(1, 0, 0, 0, 0);
        chk("R2 nested child", int'(fork_child), 2);
        chk("R2 nested parent paths", pth(0), 2);
        chk("R2 nested child paths", pth(2), 2);
        chk("R2 nested child dir", drb(2), 3'b010);
        cycle(1, 1, 0, 0, 0);
        chk("R4 shallow source ack", int'(fork_ack), 0);
        chk("R4 shallow source active", int'(ctx_active), 6'b000111);
        chk("R4 shallow source paths", pth(1), 1);
    endtask

    task automatic t_exhaust_and_depth;
        cycle(1, 0, 0, 0, 0);
        chk("R2 third child", int'(fork_child), 3);
        chk("R2 third child dir", drb(3), 3'b100);
        chk("R2 third parent paths", pth(0), 3);
        chk("R3 narrow ack", int'(n_fork_ack), 0);
        chk("R3 narrow active", int'(n_active), 3'b111);
        cycle(1, 0, 0, 0, 0);
        chk("R4 depth ack", int'(fork_ack), 0);
        chk("R4 depth active", int'(ctx_active), 6'b001111);
        chk("R4 depth paths", pth(0), 3);
    endtask

    task automatic t_resolve_chain;
        int c, k, s, r;
        cycle(0, 0, 1, 2, 0);
        chk("R5 lvl2 discard", int'(discard_mask), 6'b001000);
        chk("R5 lvl2 active", int'(ctx_active), 6'b000111);
        chk("R6 lvl2 survivor paths", pth(0), 2);
        chk("R10 lvl2 ctx2 paths", pth(2), 2);
        cycle(1, 0, 1, 1, 1);
        chk("R9 fork with resolve", int'(fork_ack), 0);
        chk("R5 lvl1 discard", int'(discard_mask), 6'b000001);
        chk("R5 lvl1 active", int'(ctx_active), 6'b000110);
        chk("R6 lvl1 survivor paths", pth(2), 1);
        chk("R6 lvl1 survivor dir", drb(2), 0);
        chk("R10 lvl1 ctx1 paths", pth(1), 1);
        chk("R10 lvl1 ctx1 dir", drb(1), 1);
        cycle(0, 0, 1, 0, 1);
        chk("R5 lvl0 discard", int'(discard_mask), 6'b000100);
        chk("R5 lvl0 active", int'(ctx_active), 6'b000010);
        chk("R6 lvl0 mode", int'(ctx_mp), 0);
        chk("R6 lvl0 dir", drb(1), 0);
        grants(1, c, k, s, r);
        chk("R7 commit after resolve", c, 1);
        chk("R7 spawn after resolve", s, 1);
        chk("R8 restart live ctx", r, 1);
        grants(0, c, k, s, r);
        chk("R8 restart idle ctx", r, 0);
        @(negedge clk);
        chk("R5 discard one cycle", int'(discard_mask), 0);
    endtask

    task automatic t_shift_down;
        cycle(1, 1, 0, 0, 0);
        chk("R2 lowest free child", int'(fork_child), 0);
        cycle(1, 1, 0, 0, 0);
        chk("R2 second child", int'(fork_child), 2);
        cycle(0, 0, 1, 0, 0);
        chk("R5 shift discard", int'(discard_mask), 6'b000001);
        chk("R6 shift ctx1 paths", pth(1), 1);
        chk("R6 shift ctx2 paths", pth(2), 1);
        chk("R6 shift ctx2 dir", drb(2), 1);
        chk("R6 shift mode", int'(ctx_mp), 6'b000110);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_first_fork;
        t_nested_fork;
        t_exhaust_and_depth;
        t_resolve_chain;
        t_shift_down;
        finish_run;
    end

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run;
    end
endmodule